// File: doc/BRIEF.md
# DMA Channel Interrupt Status Unit

This block holds the interrupt status flags and their enables for a single DMA channel and turns them into two interrupt lines: an error line and a normal-end line. The channel datapath feeds it single-cycle event pulses: a frame finished while the channel runs in chained-block mode, the whole transfer finished, and a new transfer request. With each request it also supplies the current and error descriptor addresses. A request that arrives while these two addresses are equal means the buffer ring has run dry or run over.

Frame-end events can be queued in a small counter rather than folded into one flag. While the counter is enabled, the frame-end status reads as set for as long as events are still waiting. Each write-one to that status bit retires one queued event. An event that arrives when the queue is already full raises a separate overflow error. Only an explicit clear command empties the queue. A host reaches the flags, the enables, the transfer mode and the counter through a small register port. Writes take effect at the clock edge. Reads are combinational on the address.

Top module: `dma_irq_stat`

## Requirements
- R1: Reset clears every status flag, every enable, the queue count and the queue-enable bit. It also selects single-block mode (mode register bit 0 = 0). Both interrupt lines are low during reset.
- R2: A transfer-done pulse sets the end-of-transfer flag (status bit 0). Writing 1 to bit 0 of the status register (address 0) clears it. Writing 0 leaves it unchanged. A set and a clear in the same cycle leave it set.
- R3: A frame-done pulse has no effect in single-block mode. In chained-block mode (mode register, address 2, bit 0 = 1) it never sets the end-of-transfer flag.
- R4: A transfer request sets the buffer-fault flag (status bit 2) when the current and error descriptor addresses are equal. The flag is write-1-to-clear, and a set wins over a clear in the same cycle.
- R5: A frame event that arrives while the queue count is at its maximum (2^CNT_W-1) sets the queue-overflow flag (status bit 3, write-1-to-clear) and leaves the count at its maximum.
- R6: With the queue enabled (address 3, bit 6), each chained-mode frame event raises the count by one. Status bit 1 then reads 1 exactly while the count is nonzero.
- R7: With the queue enabled, writing 1 to status bit 1 lowers the count by one and does not go below zero. A write in the same cycle as a frame event leaves a nonzero count unchanged.
- R8: Writing 1 to address 3 bit 7 empties the queue at once. This bit always reads back as 0, and the command takes priority over events.
- R9: With the queue disabled, status bit 1 acts as a plain flag that each chained-mode frame event sets and a write-1 clears. The count is held while the queue is disabled.
- R10: The error line is high one cycle after buffer-fault or queue-overflow is set with its enable set. The normal-end line is high one cycle after end-of-transfer or frame-end is set with its enable set. The enable bits sit at the same positions as the status bits (address 1).
- R11: A raised interrupt line stays high until its status flag or its enable is cleared, then falls one cycle later.
- R12: The enable, mode and queue-enable fields read back the values last written. The count reads back in address 3 bits [CNT_W-1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_done_i | input | 1 | Pulse: one frame finished in chained-block mode |
| xfer_done_i | input | 1 | Pulse: whole transfer finished |
| xfer_req_i | input | 1 | Pulse: new transfer request |
| cur_desc_i | input | AW | Current descriptor address |
| err_desc_i | input | AW | Error descriptor address |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 status, 1 enable, 2 mode, 3 queue |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational on the address |
| err_irq_o | output | 1 | Registered error interrupt |
| norm_irq_o | output | 1 | Registered normal-end interrupt |

## Verification
The bench builds the block with CNT_W = 3 and AW = 8. A queue of 7 entries fills after a handful of frame events, so overflow, saturation and the clear command all come within a short directed run. The narrow address lets the bench flip the descriptor comparison between equal and unequal with two fixed values.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int unsigned ST_W   = 4;
  localparam int unsigned ST_EOT = 0;
  localparam int unsigned ST_EOM = 1;
  localparam int unsigned ST_BOF = 2;
  localparam int unsigned ST_COF = 3;

  localparam int unsigned FC_EN_BIT  = 6;
  localparam int unsigned FC_CLR_BIT = 7;

  typedef enum logic [1:0] {
    RA_STAT = 2'd0,
    RA_ENAB = 2'd1,
    RA_MODE = 2'd2,
    RA_FCNT = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/dma_bof_detect.sv
module dma_bof_detect #(
  parameter int unsigned AW = 24
) (
  input  logic          req_i,
  input  logic [AW-1:0] cur_i,
  input  logic [AW-1:0] err_i,
  output logic          hit_o
);
  assign hit_o = req_i && (cur_i == err_i);
endmodule

// File: rtl/dma_frame_cnt.sv
module dma_frame_cnt #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             dec_eff;

  // nothing to retire at zero
  assign dec_eff = dec_i && (cnt_q != '0);
  assign ovf_o   = inc_i && !dec_eff && !clr_i && (cnt_q == CNT_MAX);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          cnt_q <= '0;
    else if (clr_i)                                       cnt_q <= '0;
    else if (inc_i && !dec_eff && (cnt_q != CNT_MAX))     cnt_q <= cnt_q + 1'b1;
    else if (dec_eff && !inc_i)                           cnt_q <= cnt_q - 1'b1;
  end

  a_r8_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  a_r5_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !clr_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
  a_r7_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !inc_i && !clr_i && cnt_q == '0) |=> (cnt_q == '0));
  a_r6_inc_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !dec_i && !clr_i && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));
  a_r9_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !dec_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/dma_irq_regs.sv
module dma_irq_regs
  import dma_irq_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic [ST_W-1:0]  status_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [ST_W-1:0]  en_o,
  output logic             chained_o,
  output logic             cnt_en_o,
  output logic [ST_W-1:0]  w1c_o,
  output logic             cnt_clr_o,
  output logic [7:0]       rdata_o
);
  reg_addr_e       ra;
  logic [ST_W-1:0] en_q;
  logic            chained_q;
  logic            cnt_en_q;
  logic            unused_wdata;

  assign ra           = reg_addr_e'(addr_i);
  assign unused_wdata = ^wdata_i[5:4];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= '0;
      chained_q <= 1'b0;
      cnt_en_q  <= 1'b0;
    end else if (we_i) begin
      case (ra)
        RA_ENAB: en_q      <= wdata_i[ST_W-1:0];
        RA_MODE: chained_q <= wdata_i[0];
        RA_FCNT: cnt_en_q  <= wdata_i[FC_EN_BIT];
        default: ;
      endcase
    end
  end

  assign w1c_o     = (we_i && ra == RA_STAT) ? wdata_i[ST_W-1:0] : '0;
  assign cnt_clr_o = we_i && (ra == RA_FCNT) && wdata_i[FC_CLR_BIT];
  assign en_o      = en_q;
  assign chained_o = chained_q;
  assign cnt_en_o  = cnt_en_q;

  always_comb begin
    rdata_o = '0;
    case (ra)
      RA_STAT: rdata_o[ST_W-1:0] = status_i;
      RA_ENAB: rdata_o[ST_W-1:0] = en_q;
      RA_MODE: rdata_o[0]        = chained_q;
      RA_FCNT: begin
        rdata_o[CNT_W-1:0] = cnt_i;
        rdata_o[FC_EN_BIT] = cnt_en_q;
      end
      default: ;
    endcase
  end

  a_r12_enab_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ra == RA_ENAB) |=> (en_q == $past(wdata_i[ST_W-1:0])));
  a_r12_mode_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && ra == RA_MODE) |=> (chained_q == $past(wdata_i[0])));
endmodule

// File: rtl/dma_irq_flags.sv
module dma_irq_flags
  import dma_irq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [ST_W-1:0] set_i,
  input  logic [ST_W-1:0] w1c_i,
  input  logic            cnt_en_i,
  input  logic            cnt_nz_i,
  output logic [ST_W-1:0] status_o
);
  logic [ST_W-1:0] flag_q;
  logic [ST_W-1:0] clr;

  always_comb begin
    clr = w1c_i;
    // queued mode: write-1 on frame-end retires a count, not the flag
    if (cnt_en_i) clr[ST_EOM] = 1'b0;
  end

  for (genvar i = 0; i < ST_W; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;
      else if (clr[i])   flag_q[i] <= 1'b0;
    end
  end

  always_comb begin
    status_o         = flag_q;
    status_o[ST_EOM] = cnt_en_i ? cnt_nz_i : flag_q[ST_EOM];
  end

  a_r2_eot_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[ST_EOT] |=> flag_q[ST_EOT]);
  a_r4_bof_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[ST_BOF] |=> flag_q[ST_BOF]);
  a_r2_write0_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[ST_EOT] && !w1c_i[ST_EOT]) |=> flag_q[ST_EOT]);
  a_r5_cof_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[ST_COF] && !w1c_i[ST_COF]) |=> flag_q[ST_COF]);
endmodule

// File: rtl/dma_irq_stat.sv
module dma_irq_stat
  import dma_irq_pkg::*;
#(
  parameter int unsigned AW    = 24,
  parameter int unsigned CNT_W = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          frame_done_i,
  input  logic          xfer_done_i,
  input  logic          xfer_req_i,
  input  logic [AW-1:0] cur_desc_i,
  input  logic [AW-1:0] err_desc_i,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  output logic [7:0]    reg_rdata_o,
  output logic          err_irq_o,
  output logic          norm_irq_o
);
  localparam logic [ST_W-1:0] ERR_MASK  = (ST_W'(1) << ST_BOF) | (ST_W'(1) << ST_COF);
  localparam logic [ST_W-1:0] NORM_MASK = (ST_W'(1) << ST_EOT) | (ST_W'(1) << ST_EOM);

  logic [ST_W-1:0]  en, w1c, status, set;
  logic             chained, cnt_en, cnt_clr, bof_hit, frame_ev, ovf;
  logic [CNT_W-1:0] cnt;
  logic             err_q, norm_q;

  dma_bof_detect #(.AW(AW)) u_bof (
    .req_i (xfer_req_i),
    .cur_i (cur_desc_i),
    .err_i (err_desc_i),
    .hit_o (bof_hit)
  );

  dma_irq_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .status_i  (status),
    .cnt_i     (cnt),
    .en_o      (en),
    .chained_o (chained),
    .cnt_en_o  (cnt_en),
    .w1c_o     (w1c),
    .cnt_clr_o (cnt_clr),
    .rdata_o   (reg_rdata_o)
  );

  // frame events exist only in chained-block mode
  assign frame_ev = frame_done_i && chained;

  dma_frame_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (frame_ev && cnt_en),
    .dec_i  (w1c[ST_EOM] && cnt_en),
    .clr_i  (cnt_clr),
    .cnt_o  (cnt),
    .ovf_o  (ovf)
  );

  always_comb begin
    set         = '0;
    set[ST_EOT] = xfer_done_i;
    set[ST_EOM] = frame_ev && !cnt_en;
    set[ST_BOF] = bof_hit;
    set[ST_COF] = ovf;
  end

  dma_irq_flags u_flags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set),
    .w1c_i    (w1c),
    .cnt_en_i (cnt_en),
    .cnt_nz_i (cnt != '0),
    .status_o (status)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      norm_q <= 1'b0;
    end else begin
      err_q  <= |(status & en & ERR_MASK);
      norm_q <= |(status & en & NORM_MASK);
    end
  end

  assign err_irq_o  = err_q;
  assign norm_irq_o = norm_q;

  a_r10_err_bof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[ST_BOF] && en[ST_BOF]) |=> err_irq_o);
  a_r10_err_cof: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[ST_COF] && en[ST_COF]) |=> err_irq_o);
  a_r10_norm_eot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status[ST_EOT] && en[ST_EOT]) |=> norm_irq_o);
  a_r11_err_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status & en & ERR_MASK) == '0) |=> !err_irq_o);
  a_r3_single_no_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done_i && !chained && !cnt_clr && !w1c[ST_EOM]) |=> $stable(cnt));
endmodule

// File: tb/dma_irq_stat_test.sv
module dma_irq_stat_test;
  localparam int unsigned AW    = 8;
  localparam int unsigned CNT_W = 3;
  localparam int unsigned NV    = 27;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          frame_done = 1'b0, xfer_done = 1'b0, xfer_req = 1'b0;
  logic [AW-1:0] cur_desc = 8'h34;
  logic [AW-1:0] err_desc = 8'h33;
  logic          we = 1'b0;
  logic [1:0]    addr = 2'd0;
  logic [7:0]    wdata = 8'h00;
  logic [7:0]    rdata;
  logic          err_irq, norm_irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  dma_irq_stat #(.AW(AW), .CNT_W(CNT_W)) uut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .frame_done_i (frame_done),
    .xfer_done_i  (xfer_done),
    .xfer_req_i   (xfer_req),
    .cur_desc_i   (cur_desc),
    .err_desc_i   (err_desc),
    .reg_we_i     (reg_we_wire),
    .reg_addr_i   (addr),
    .reg_wdata_i  (wdata),
    .reg_rdata_o  (rdata),
    .err_irq_o    (err_irq),
    .norm_irq_o   (norm_irq)
  );
  logic reg_we_wire;
  assign reg_we_wire = we;

  // {f,x,r,eq} we addr pad wdata | status fcnt {err,norm} pad
  localparam logic [31:0] VEC [NV] = '{
    {4'b0000, 1'b1, 2'd1, 1'b0, 8'h0F, 4'h0, 8'h00, 2'b00, 2'b00}, // R12 enable all
    {4'b0100, 1'b0, 2'd0, 1'b0, 8'h00, 4'h1, 8'h00, 2'b00, 2'b00}, // R2 set
    {4'b0000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h1, 8'h00, 2'b01, 2'b00}, // R10 norm
    {4'b0000, 1'b1, 2'd0, 1'b0, 8'h0E, 4'h1, 8'h00, 2'b01, 2'b00}, // R2 write 0 keeps
    {4'b0000, 1'b1, 2'd0, 1'b0, 8'h01, 4'h0, 8'h00, 2'b01, 2'b00}, // R2 clear
    {4'b0000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h0, 8'h00, 2'b00, 2'b00}, // R11 drop
    {4'b1000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h0, 8'h00, 2'b00, 2'b00}, // R3 single ignored
    {4'b0000, 1'b1, 2'd2, 1'b0, 8'h01, 4'h0, 8'h00, 2'b00, 2'b00}, // R12 chained
    {4'b1000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h2, 8'h00, 2'b00, 2'b00}, // R9 R3 flag, no EOT
    {4'b0000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h2, 8'h00, 2'b01, 2'b00}, // R10
    {4'b0000, 1'b1, 2'd0, 1'b0, 8'h02, 4'h0, 8'h00, 2'b01, 2'b00}, // R9 clear
    {4'b0000, 1'b1, 2'd3, 1'b0, 8'h40, 4'h0, 8'h40, 2'b00, 2'b00}, // R12 queue on
    {4'b1000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h2, 8'h41, 2'b00, 2'b00}, // R6
    {4'b1000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h2, 8'h42, 2'b01, 2'b00}, // R6
    {4'b0000, 1'b1, 2'd0, 1'b0, 8'h02, 4'h2, 8'h41, 2'b01, 2'b00}, // R7 dec
    {4'b1000, 1'b1, 2'd0, 1'b0, 8'h02, 4'h2, 8'h41, 2'b01, 2'b00}, // R7 dec+inc
    {4'b0000, 1'b1, 2'd0, 1'b0, 8'h02, 4'h0, 8'h40, 2'b01, 2'b00}, // R7 to zero
    {4'b0000, 1'b1, 2'd0, 1'b0, 8'h02, 4'h0, 8'h40, 2'b00, 2'b00}, // R7 floor
    {4'b0011, 1'b0, 2'd0, 1'b0, 8'h00, 4'h4, 8'h40, 2'b00, 2'b00}, // R4 set
    {4'b0010, 1'b1, 2'd0, 1'b0, 8'h04, 4'h0, 8'h40, 2'b10, 2'b00}, // R4 clear, R10 err
    {4'b0010, 1'b0, 2'd0, 1'b0, 8'h00, 4'h0, 8'h40, 2'b00, 2'b00}, // R4 unequal
    {4'b0100, 1'b1, 2'd1, 1'b0, 8'h00, 4'h1, 8'h40, 2'b00, 2'b00}, // R12 disable all
    {4'b0000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h1, 8'h40, 2'b00, 2'b00}, // R10 masked
    {4'b0011, 1'b1, 2'd0, 1'b0, 8'h04, 4'h5, 8'h40, 2'b00, 2'b00}, // R4 set wins
    {4'b0000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h5, 8'h40, 2'b00, 2'b00},
    {4'b0000, 1'b1, 2'd1, 1'b0, 8'h04, 4'h5, 8'h40, 2'b00, 2'b00}, // R10 bof only
    {4'b0000, 1'b0, 2'd0, 1'b0, 8'h00, 4'h5, 8'h40, 2'b10, 2'b00}  // R10 err only
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic f, input logic x, input logic r, input logic e,
                      input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    frame_done = f; xfer_done = x; xfer_req = r;
    cur_desc = e ? 8'h33 : 8'h34;
    we = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    frame_done = 1'b0; xfer_done = 1'b0; xfer_req = 1'b0;
    cur_desc = 8'h34; we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    addr = a;
    #1;
    v = rdata;
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, a, d);
  endtask

  initial begin
    logic [7:0] v;
    logic       ie, in;
    #23;
    // R1 reset state
    rd(2'd0, v); chk("R1 status", v, 8'h00);
    rd(2'd1, v); chk("R1 enable", v, 8'h00);
    rd(2'd2, v); chk("R1 mode", v, 8'h00);
    rd(2'd3, v); chk("R1 queue", v, 8'h00);
    chk("R1 irq", {6'b0, err_irq, norm_irq}, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [31:0] t;
      t = VEC[i];
      step(t[31], t[30], t[29], t[28], t[27], t[26:25], t[23:16]);
      ie = err_irq; in = norm_irq;
      chk($sformatf("table row %0d irq", i), {6'b0, ie, in}, {6'b0, t[3:2]});
      rd(2'd0, v); chk($sformatf("table row %0d status", i), v, {4'h0, t[15:12]});
      rd(2'd3, v); chk($sformatf("table row %0d queue", i), v, t[11:4]);
    end

    // R5 overflow at full queue
    wr(2'd1, 8'h0F);
    wr(2'd0, 8'h05);
    rd(2'd0, v); chk("R2 R4 cleared", v, 8'h00);
    for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); chk("R5 full no ovf", v, 8'h02);
    rd(2'd3, v); chk("R5 full count", v, 8'h47);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); chk("R5 ovf set", v, 8'h0A);
    rd(2'd3, v); chk("R5 saturate", v, 8'h47);
    idle();
    chk("R5 R10 err line", {7'b0, err_irq}, 8'h01);

    // R8 clear command
    wr(2'd3, 8'hC0);
    rd(2'd3, v); chk("R8 emptied", v, 8'h40);
    rd(2'd0, v); chk("R8 ovf kept", v, 8'h08);
    wr(2'd0, 8'h08);
    rd(2'd0, v); chk("R5 ovf cleared", v, 8'h00);
    idle();
    chk("R11 lines low", {6'b0, err_irq, norm_irq}, 8'h00);

    // R9 queue disabled holds count, flag mode
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R9 count held", v, 8'h03);
    rd(2'd0, v); chk("R9 flag clear", v, 8'h00);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); chk("R9 flag set", v, 8'h02);
    rd(2'd3, v); chk("R9 count still", v, 8'h03);
    wr(2'd0, 8'h02);
    rd(2'd0, v); chk("R9 flag w1c", v, 8'h00);
    wr(2'd3, 8'h80);
    rd(2'd3, v); chk("R8 clear while off", v, 8'h00);

    // R3 back to single-block
    wr(2'd2, 8'h00);
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
    rd(2'd0, v); chk("R3 single ignored", v, 8'h00);
    rd(2'd2, v); chk("R12 mode readback", v, 8'h00);
    rd(2'd1, v); chk("R12 enable readback", v, 8'h0F);

    // R1 reset mid-run
    wr(2'd2, 8'h01);
    step(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'd0, 8'h00);
    idle();
    chk("R10 both lines", {6'b0, err_irq, norm_irq}, 8'h03);
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 irq in reset", {6'b0, err_irq, norm_irq}, 8'h00);
    rd(2'd0, v); chk("R1 status in reset", v, 8'h00);
    rd(2'd1, v); chk("R1 enable in reset", v, 8'h00);
    rd(2'd2, v); chk("R1 mode in reset", v, 8'h00);
    @(negedge clk);
    rst_ni = 1'b1;

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule